// File: doc/BRIEF.md
# Programmable-Timing Parallel Bus Master

This block drives an external parallel memory-style bus (NOR flash, an FPGA, a peripheral chip) on behalf of an internal requester. A request carries a direction, an address and write data. The master asserts one of several chip selects and steps through a fixed series of bus phases. It returns read data with a one-cycle done strobe once the bus is quiet again. The block does no address decoding between devices, so each transaction goes out on exactly one selected chip-select pin.

Each phase has its own cycle count, and a programmed value N always lasts N+1 clocks. The phases are chip-select setup, address valid, an optional multiplexed-address phase, the read or write strobe, a bounded wait for the device's ready line, and chip-select hold. The phase counts, the bus mode and the selected pin are sampled when a request is accepted. The line polarities and the ready polarity are taken live from their configuration inputs. The data path is 16 bits wide by default, and a configuration input widens it to 32. In multiplexed mode the address travels on the shared data lines ahead of the data. The device may signal ready either together with valid read data or one clock ahead of it.

Top module: `parbus_master`

## Requirements
- R1: While the internal reset is active and after it, until a request arrives: every chip select, address-valid, output-enable and write-enable pin sits at its inactive level, the data driver is off, rsp_done is low, rsp_rdata is zero and req_ready is high.
- R2: An accepted request runs these phases in order, each lasting its programmed value plus one clock: setup (cfg_setup, chip select only), address valid (cfg_adv, address-valid asserted), multiplexed address (cfg_mux, only when cfg_muxed=1), strobe (cfg_oe on reads with output-enable asserted, cfg_we on writes with write-enable asserted), wait, and hold.
- R3: With cfg_muxed=1 the address is driven on bus_dout with bus_doe=1 throughout the address-valid and multiplexed-address phases. With cfg_muxed=0 there is no multiplexed phase and no address on the data lines. bus_addr carries the request address for the whole transaction.
- R4: bus_doe is 1 only in the multiplexed address phases and, on writes, in the strobe, wait and capture cycles. It is never 1 while output-enable is asserted. bus_dout is zero whenever bus_doe is 0.
- R5: After the strobe is released, the selected chip select stays asserted for cfg_hold+1 clocks.
- R6: Setting cfg_cs_hi, cfg_adv_hi, cfg_strb_hi (shared by output-enable and write-enable) or cfg_rdy_hi makes that line active high. Clearing the bit makes it active low.
- R7: In the wait phase the strobe stays asserted and ready is sampled every clock. With cfg_rdy_early=0, read data is captured in the clock where ready is seen. With cfg_rdy_early=1, one extra capture clock follows with the strobe still asserted, and the data is captured there.
- R8: With cfg_wide=0, only bus bits 15:0 carry data or address: the upper half of bus_dout and of rsp_rdata is zero. With cfg_wide=1, all 32 bits are used.
- R9: cfg_cs_sel (0..7) picks which bus_cs bit is asserted. At most one chip select is ever active.
- R10: If ready is not seen within cfg_tmo+1 wait clocks, the transaction moves on to hold, and rsp_timeout is 1 together with rsp_done, with rsp_rdata zero. Ready seen in the last wait clock is not a timeout.
- R11: rsp_done is a single-clock pulse in the first idle clock after hold. req_ready is high exactly while idle, and a new request is accepted in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present; accepted when req_ready is high |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (28) | Request address |
| req_wdata | input | DW (32) | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_timeout | output | 1 | Ready never seen; valid with rsp_done |
| rsp_rdata | output | DW (32) | Captured read data |
| cfg_setup | input | 4 | Chip-select setup count |
| cfg_adv | input | 4 | Address-valid count |
| cfg_mux | input | 4 | Multiplexed-address count |
| cfg_we | input | 4 | Write strobe count |
| cfg_hold | input | 4 | Chip-select hold count |
| cfg_oe | input | 8 | Read strobe count |
| cfg_tmo | input | 8 | Wait-for-ready limit |
| cfg_muxed | input | 1 | Address/data multiplexed mode |
| cfg_wide | input | 1 | 32-bit data path |
| cfg_rdy_early | input | 1 | Ready comes one clock before data |
| cfg_cs_sel | input | 3 | Chip-select pin index |
| cfg_rdy_hi | input | 1 | Ready active high |
| cfg_adv_hi | input | 1 | Address-valid active high |
| cfg_cs_hi | input | 1 | Chip selects active high |
| cfg_strb_hi | input | 1 | Output/write enables active high |
| bus_cs | output | CSN (8) | Chip-select pins |
| bus_adv | output | 1 | Address-valid pin |
| bus_oe | output | 1 | Output-enable pin |
| bus_we | output | 1 | Write-enable pin |
| bus_addr | output | AW (28) | Address lines |
| bus_dout | output | DW (32) | Shared data lines, outgoing value |
| bus_doe | output | 1 | Drive enable for bus_dout |
| bus_din | input | DW (32) | Shared data lines, incoming value |
| bus_rdy | input | 1 | Device ready |

## Verification
The assertions assume the four polarity inputs stay constant while a transaction is in flight, because the pin levels follow them live. The bench changes polarity only between transactions, while the block is idle. The assertions also assume that ready is sampled only in the wait phase. The bench therefore holds ready at its active level from a chosen wait clock until done, sometimes too late and sometimes never, so both the capture path and the timeout path are reached. Read data is driven to a distinct value only in the one clock where capture must happen. Request fields are changed right after acceptance, which shows that the block works from its own snapshot.

// File: rtl/parbus_pkg.sv
package parbus_pkg;

  localparam int SHORT_W = 4;
  localparam int LONG_W  = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_ADV, PH_MUX, PH_STRB, PH_WAIT, PH_CAPT, PH_HOLD
  } phase_e;

  typedef struct packed {
    logic [SHORT_W-1:0] setup;
    logic [SHORT_W-1:0] adv;
    logic [SHORT_W-1:0] mux;
    logic [SHORT_W-1:0] we;
    logic [SHORT_W-1:0] hold;
    logic [LONG_W-1:0]  oe;
    logic [LONG_W-1:0]  tmo;
    logic               muxed;
    logic               wide;
    logic               rdy_early;
  } timing_t;

  localparam timing_t TIMING_RESET = '{setup: 4'd4, adv: 4'd1, mux: 4'd1, we: 4'd1,
                                       hold: 4'd1, oe: 8'd1, tmo: 8'd3,
                                       muxed: 1'b0, wide: 1'b0, rdy_early: 1'b0};

endpackage

// File: rtl/parbus_phase_ctr.sv
module parbus_phase_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load)       cnt_d = val;
    else if (!zero) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/parbus_pins.sv
module parbus_pins #(
  parameter  int CSN = 8,
  localparam int CSW = $clog2(CSN)
) (
  input  logic           cs_on,
  input  logic           adv_on,
  input  logic           oe_on,
  input  logic           we_on,
  input  logic [CSW-1:0] cs_sel,
  input  logic           cs_hi,
  input  logic           adv_hi,
  input  logic           strb_hi,
  output logic [CSN-1:0] cs_pin,
  output logic           adv_pin,
  output logic           oe_pin,
  output logic           we_pin
);

  for (genvar g = 0; g < CSN; g++) begin : g_cs
    assign cs_pin[g] = (cs_on & (cs_sel == CSW'(g))) ^ ~cs_hi;
  end

  assign adv_pin = adv_on ^ ~adv_hi;
  assign oe_pin  = oe_on  ^ ~strb_hi;
  assign we_pin  = we_on  ^ ~strb_hi;

endmodule

// File: rtl/parbus_master.sv
module parbus_master
  import parbus_pkg::*;
#(
  parameter  int AW  = 28,
  parameter  int DW  = 32,
  parameter  int CSN = 8,
  localparam int CSW = $clog2(CSN),
  localparam int HW  = DW / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic                rsp_done,
  output logic                rsp_timeout,
  output logic [DW-1:0]       rsp_rdata,
  input  logic [SHORT_W-1:0]  cfg_setup,
  input  logic [SHORT_W-1:0]  cfg_adv,
  input  logic [SHORT_W-1:0]  cfg_mux,
  input  logic [SHORT_W-1:0]  cfg_we,
  input  logic [SHORT_W-1:0]  cfg_hold,
  input  logic [LONG_W-1:0]   cfg_oe,
  input  logic [LONG_W-1:0]   cfg_tmo,
  input  logic                cfg_muxed,
  input  logic                cfg_wide,
  input  logic                cfg_rdy_early,
  input  logic [CSW-1:0]      cfg_cs_sel,
  input  logic                cfg_rdy_hi,
  input  logic                cfg_adv_hi,
  input  logic                cfg_cs_hi,
  input  logic                cfg_strb_hi,
  output logic [CSN-1:0]      bus_cs,
  output logic                bus_adv,
  output logic                bus_oe,
  output logic                bus_we,
  output logic [AW-1:0]       bus_addr,
  output logic [DW-1:0]       bus_dout,
  output logic                bus_doe,
  input  logic [DW-1:0]       bus_din,
  input  logic                bus_rdy
);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_nq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_nq = rsync_q[1];

  phase_e         st_q, st_d;
  timing_t        tm_q, tm_d;
  logic [CSW-1:0] sel_q, sel_d;
  logic           wr_q, wr_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [DW-1:0]  wd_q, wd_d;
  logic [DW-1:0]  rd_q, rd_d;
  logic           done_q, done_d;
  logic           to_q, to_d;
  logic           capture;
  logic           ctr_load;
  logic [LONG_W-1:0] ctr_val;
  logic           ctr_zero;
  logic           rdy_on;
  logic [DW-1:0]  lane_mask;
  logic           addr_ph;
  logic           strb_ph;

  function automatic logic [LONG_W-1:0] widen(input logic [SHORT_W-1:0] v);
    return LONG_W'(v);
  endfunction

  assign rdy_on    = cfg_rdy_hi ? bus_rdy : ~bus_rdy;
  assign lane_mask = tm_q.wide ? {DW{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}};

  // next-state logic
  always_comb begin
    st_d    = st_q;
    tm_d    = tm_q;
    sel_d   = sel_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    wd_d    = wd_q;
    rd_d    = rd_q;
    to_d    = to_q;
    done_d  = 1'b0;
    capture = 1'b0;
    case (st_q)
      PH_IDLE: if (req_valid) begin
        st_d   = PH_SETUP;
        tm_d   = '{setup: cfg_setup, adv: cfg_adv, mux: cfg_mux, we: cfg_we,
                   hold: cfg_hold, oe: cfg_oe, tmo: cfg_tmo, muxed: cfg_muxed,
                   wide: cfg_wide, rdy_early: cfg_rdy_early};
        sel_d  = cfg_cs_sel;
        wr_d   = req_write;
        addr_d = req_addr;
        wd_d   = req_wdata;
        rd_d   = '0;
        to_d   = 1'b0;
      end
      PH_SETUP: if (ctr_zero) st_d = PH_ADV;
      PH_ADV:   if (ctr_zero) st_d = tm_q.muxed ? PH_MUX : PH_STRB;
      PH_MUX:   if (ctr_zero) st_d = PH_STRB;
      PH_STRB:  if (ctr_zero) st_d = PH_WAIT;
      PH_WAIT: begin
        if (rdy_on) begin
          if (tm_q.rdy_early) st_d = PH_CAPT;
          else begin
            st_d    = PH_HOLD;
            capture = 1'b1;
          end
        end else if (ctr_zero) begin
          st_d = PH_HOLD;
          to_d = 1'b1;
        end
      end
      PH_CAPT: begin
        st_d    = PH_HOLD;
        capture = 1'b1;
      end
      PH_HOLD: if (ctr_zero) begin
        st_d   = PH_IDLE;
        done_d = 1'b1;
      end
      default: st_d = PH_IDLE;
    endcase
    if (capture && !wr_q) rd_d = bus_din & lane_mask;

    ctr_load = (st_d != st_q);
    case (st_d)
      PH_SETUP: ctr_val = widen(tm_d.setup);
      PH_ADV:   ctr_val = widen(tm_d.adv);
      PH_MUX:   ctr_val = widen(tm_d.mux);
      PH_STRB:  ctr_val = wr_d ? widen(tm_d.we) : tm_d.oe;
      PH_WAIT:  ctr_val = tm_d.tmo;
      PH_HOLD:  ctr_val = widen(tm_d.hold);
      default:  ctr_val = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_nq) begin
    if (!rst_nq) begin
      st_q   <= PH_IDLE;
      tm_q   <= TIMING_RESET;
      sel_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      tm_q   <= tm_d;
      sel_q  <= sel_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      rd_q   <= rd_d;
      done_q <= done_d;
      to_q   <= to_d;
    end
  end

  parbus_phase_ctr #(.W(LONG_W)) i_ctr (
    .clk   (clk),
    .rst_n (rst_nq),
    .load  (ctr_load),
    .val   (ctr_val),
    .zero  (ctr_zero)
  );

  assign addr_ph = tm_q.muxed & ((st_q == PH_ADV) | (st_q == PH_MUX));
  assign strb_ph = (st_q == PH_STRB) | (st_q == PH_WAIT) | (st_q == PH_CAPT);

  parbus_pins #(.CSN(CSN)) i_pins (
    .cs_on   (st_q != PH_IDLE),
    .adv_on  (st_q == PH_ADV),
    .oe_on   (strb_ph & ~wr_q),
    .we_on   (strb_ph & wr_q),
    .cs_sel  (sel_q),
    .cs_hi   (cfg_cs_hi),
    .adv_hi  (cfg_adv_hi),
    .strb_hi (cfg_strb_hi),
    .cs_pin  (bus_cs),
    .adv_pin (bus_adv),
    .oe_pin  (bus_oe),
    .we_pin  (bus_we)
  );

  assign bus_addr    = addr_q;
  assign bus_doe     = addr_ph | (wr_q & strb_ph);
  assign bus_dout    = addr_ph ? (DW'(addr_q) & lane_mask)
                     : (wr_q & strb_ph) ? (wd_q & lane_mask) : '0;
  assign req_ready   = (st_q == PH_IDLE);
  assign rsp_done    = done_q;
  assign rsp_timeout = done_q & to_q;
  assign rsp_rdata   = rd_q;

  // R9
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_nq)
    $onehot0(cfg_cs_hi ? bus_cs : ~bus_cs));

  // R4
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_nq)
    (cfg_strb_hi ? bus_oe : ~bus_oe) |-> !bus_doe);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_nq)
    rsp_done |=> !rsp_done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_nq)
    rsp_done |-> req_ready);

  // R5
  hold_cs_chk: assert property (@(posedge clk) disable iff (!rst_nq)
    (st_q == PH_HOLD) |-> ((cfg_cs_hi ? bus_cs : ~bus_cs) != '0));

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_nq)
    (st_q != PH_IDLE && st_q != PH_WAIT && st_q != PH_CAPT && !ctr_zero)
      |=> (st_q == $past(st_q)));

endmodule

// File: tb/test_parbus_master.sv
module test_parbus_master;

  localparam int AW = 28;
  localparam int DW = 32;
  localparam int CSN = 8;

  localparam int P_IDLE = 0, P_SETUP = 1, P_ADV = 2, P_MUX = 3,
                 P_STRB = 4, P_WAIT = 5, P_CAPT = 6, P_HOLD = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic rsp_done, rsp_timeout;
  logic [DW-1:0] rsp_rdata;
  logic [3:0] cfg_setup, cfg_adv, cfg_mux, cfg_we, cfg_hold;
  logic [7:0] cfg_oe, cfg_tmo;
  logic cfg_muxed, cfg_wide, cfg_rdy_early;
  logic [2:0] cfg_cs_sel;
  logic cfg_rdy_hi, cfg_adv_hi, cfg_cs_hi, cfg_strb_hi;
  logic [CSN-1:0] bus_cs;
  logic bus_adv, bus_oe, bus_we, bus_doe, bus_rdy;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout, bus_din;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  parbus_master i_parbus_master (.*);

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic set_timing(input int s, input int a, input int m, input int w,
                            input int h, input int o, input int t);
    cfg_setup = 4'(s); cfg_adv = 4'(a); cfg_mux = 4'(m); cfg_we = 4'(w);
    cfg_hold = 4'(h); cfg_oe = 8'(o); cfg_tmo = 8'(t);
  endtask

  // Reference model: builds the expected phase per cycle, drives ready/data,
  // and compares every pin on every clock of the transaction.
  task automatic run(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                     input int k, input logic [DW-1:0] good);
    int ph[$];
    int wstart, cap_off, len;
    bit tmo_exp;
    logic [DW-1:0] mask, exp_rd, exp_dout;
    logic [CSN-1:0] exp_cs;
    bit rdy_i, cs_on, adv_on, strb_on, doe;
    int p;
    mask = cfg_wide ? 32'hffff_ffff : 32'h0000_ffff;
    for (int i = 0; i <= int'(cfg_setup); i++) ph.push_back(P_SETUP);
    for (int i = 0; i <= int'(cfg_adv); i++) ph.push_back(P_ADV);
    if (cfg_muxed) for (int i = 0; i <= int'(cfg_mux); i++) ph.push_back(P_MUX);
    for (int i = 0; i <= (wr ? int'(cfg_we) : int'(cfg_oe)); i++) ph.push_back(P_STRB);
    wstart = ph.size();
    if (k >= 0 && k <= int'(cfg_tmo)) begin
      for (int i = 0; i <= k; i++) ph.push_back(P_WAIT);
      if (cfg_rdy_early) ph.push_back(P_CAPT);
      cap_off = ph.size() - 1;
      tmo_exp = 1'b0;
    end else begin
      for (int i = 0; i <= int'(cfg_tmo); i++) ph.push_back(P_WAIT);
      cap_off = -1;
      tmo_exp = 1'b1;
    end
    for (int i = 0; i <= int'(cfg_hold); i++) ph.push_back(P_HOLD);
    len = ph.size();
    exp_rd = (tmo_exp || wr) ? '0 : (good & mask);

    @(negedge clk);
    chk("R11", "req_ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~wd; req_write = ~wr;
    for (int t = 0; t <= len; t++) begin
      rdy_i = (k >= 0) && (t >= wstart + k);
      bus_rdy = cfg_rdy_hi ? rdy_i : ~rdy_i;
      bus_din = (t == cap_off) ? good : ~good;
      @(negedge clk);
      p = (t < len) ? ph[t] : P_IDLE;
      cs_on   = (p != P_IDLE);
      adv_on  = (p == P_ADV);
      strb_on = (p == P_STRB) || (p == P_WAIT) || (p == P_CAPT);
      doe     = (cfg_muxed && (p == P_ADV || p == P_MUX)) || (wr && strb_on);
      exp_cs  = cs_on ? (CSN'(1) << cfg_cs_sel) : '0;
      if (!cfg_cs_hi) exp_cs = ~exp_cs;
      if (!doe) exp_dout = '0;
      else if (p == P_ADV || p == P_MUX) exp_dout = DW'(a) & mask;
      else exp_dout = wd & mask;
      chk("R5 R9", "bus_cs", bus_cs, exp_cs);
      chk("R2 R6", "bus_adv", bus_adv, adv_on ^ !cfg_adv_hi);
      chk("R2 R6", "bus_oe", bus_oe, (strb_on && !wr) ^ !cfg_strb_hi);
      chk("R2 R6", "bus_we", bus_we, (strb_on && wr) ^ !cfg_strb_hi);
      chk("R4", "bus_doe", bus_doe, doe);
      chk("R3 R8", "bus_dout", bus_dout, exp_dout);
      chk("R11", "rsp_done", rsp_done, (t == len));
      chk("R11", "req_ready", req_ready, (t == len));
      if (t < len) chk("R3", "bus_addr", bus_addr, a);
      if (t == len) begin
        chk("R10", "rsp_timeout", rsp_timeout, tmo_exp);
        chk("R7 R8", "rsp_rdata", rsp_rdata, exp_rd);
      end
      @(posedge clk); #1;
    end
    bus_rdy = cfg_rdy_hi ? 1'b0 : 1'b1;
    @(negedge clk);
    chk("R11", "rsp_done after pulse", rsp_done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    set_timing(4, 1, 1, 1, 1, 1, 3);
    cfg_muxed = 0; cfg_wide = 0; cfg_rdy_early = 0; cfg_cs_sel = 0;
    cfg_rdy_hi = 0; cfg_adv_hi = 0; cfg_cs_hi = 0; cfg_strb_hi = 0;
    bus_rdy = 1'b1; bus_din = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "cs in reset", bus_cs, 8'hff);
    chk("R1", "done in reset", rsp_done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after reset
    chk("R1", "cs idle", bus_cs, 8'hff);
    chk("R1", "adv idle", bus_adv, 1);
    chk("R1", "oe idle", bus_oe, 1);
    chk("R1", "we idle", bus_we, 1);
    chk("R1", "doe idle", bus_doe, 0);
    chk("R1", "rdata idle", rsp_rdata, 0);
    chk("R1", "req_ready idle", req_ready, 1);

    // R2 R7 R8: reset-default timing read, narrow, non-muxed
    run(1'b0, 28'h123_4567, '0, 1, 32'hcafe_beef);
    // R3 R8 R9: muxed wide write on CS5, ready immediately
    cfg_muxed = 1; cfg_wide = 1; cfg_cs_sel = 5;
    set_timing(2, 0, 3, 2, 2, 1, 3);
    run(1'b1, 28'hab_cdef0, 32'h8765_4321, 0, '0);
    // R6 R7: all lines active high, early ready, CS7
    cfg_rdy_hi = 1; cfg_adv_hi = 1; cfg_cs_hi = 1; cfg_strb_hi = 1;
    cfg_rdy_early = 1; cfg_cs_sel = 7;
    set_timing(1, 2, 1, 1, 3, 2, 4);
    run(1'b0, 28'h000_0042, '0, 2, 32'h1357_9bdf);
    // R10: read timeout, ready never arrives
    cfg_rdy_hi = 0; cfg_adv_hi = 0; cfg_cs_hi = 0; cfg_strb_hi = 0;
    cfg_rdy_early = 0; cfg_muxed = 0; cfg_cs_sel = 2;
    set_timing(0, 0, 0, 0, 0, 0, 2);
    run(1'b0, 28'h0ff_ff00, '0, -1, 32'hdead_0001);
    // R2 R7: all phases one clock, early-ready write, narrow muxed
    cfg_wide = 0; cfg_muxed = 1; cfg_rdy_early = 1; cfg_cs_sel = 1;
    set_timing(0, 0, 0, 0, 0, 0, 0);
    run(1'b1, 28'h765_4321, 32'hffff_a5a5, 0, '0);
    // R10 boundary: ready in the last wait clock is not a timeout
    cfg_muxed = 0; cfg_rdy_early = 0; cfg_wide = 1; cfg_cs_sel = 3;
    set_timing(15, 15, 15, 15, 15, 255, 20);
    run(1'b0, 28'h555_aaaa, '0, 20, 32'h2468_ace0);
    // R10: ready one clock too late
    set_timing(3, 1, 1, 1, 1, 4, 5);
    run(1'b0, 28'h111_2222, '0, 6, 32'h0bad_f00d);
    // R8: narrow read masks upper half
    cfg_wide = 0; cfg_cs_sel = 6;
    run(1'b0, 28'h333_4444, '0, 3, 32'hffff_ffff);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule